// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block decides which of a set of DMA channels is started next. Each channel presents a request line, a 4-bit priority, a bit that allows it to be interrupted, and a bit that allows it to interrupt others. The engine reports the channel it is currently executing, if any. When no channel is executing, the arbiter picks one requester. It uses either a highest-priority-wins rule or a rotating search, and a global mode input chooses between them. When a channel is executing, a waiting requester can take over only through preemption. The arbiter then raises a suspend request for the running channel and grants the newcomer.

The arbiter also watches the priority set for duplicates and reports a conflict. A halt state can be armed so that any error, whether a reported channel error or a priority conflict, stops all new starts until software clears it. A debug input blocks every new start, preemptions included, and lets the running channel continue. Grant outputs are combinational from the current inputs and state. Only the halt state and the rotation pointer are registered.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset no grant is given, the halt state is clear, and the first rotating search begins at channel 0.
- R2: In fixed mode (`rr_mode`=0) with no active channel, the requesting channel whose 4-bit priority field (channel i at bits [4i+3:4i] of `prio`) is numerically greatest is granted. `grant_vec` has exactly that bit set.
- R3: In rotating mode (`rr_mode`=1) with no active channel, the first requester after the channel last granted is chosen, wrapping from the top index to 0. A grant in rotating mode moves the pointer to the granted channel at the next clock edge.
- R4: With no request present, `grant_valid` is 0 and `grant_vec` is all zero.
- R5: With `act_valid`=1, a grant is given together with `suspend_req`=1 only when three conditions hold. The active channel's `preempt_en` bit is 1. The requester has its `preempt_ab` bit set. The requester's priority is strictly greater than the active channel's. The requester granted is the greatest-priority one among those able to preempt.
- R6: With `act_valid`=1, a requester whose priority is lower than or equal to the active channel's receives no grant.
- R7: If the active channel's `preempt_en` bit is 0, no preemption grant occurs.
- R8: A requester with its `preempt_ab` bit 0 never preempts, even when its priority is greater.
- R9: `prio_err` is 1 in any cycle where two channels hold equal priority values, and 0 when all are distinct.
- R10: With `halt_on_err`=1, an error (`err_in`=1 or `prio_err`=1) sets `halted` at the next edge, and while `halted`=1 there is no grant and no suspend. With `halt_on_err`=0, errors never set `halted`.
- R11: While `dbg_mode`=1, `grant_valid` and `suspend_req` are 0 in that same cycle. Grants resume in the first cycle after it drops.
- R12: `halt_clr`=1 clears `halted` at the next edge, unless a halting error is present in the same cycle, in which case the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_mode | input | 1 | 1 = rotating selection, 0 = fixed priority |
| halt_on_err | input | 1 | Arms halting on any error |
| halt_clr | input | 1 | Software clear of the halt state |
| dbg_mode | input | 1 | Blocks all new starts |
| err_in | input | 1 | Error reported by a running channel |
| req | input | NCH | Per-channel service requests |
| prio | input | NCH*PW | Per-channel priorities, channel i at [PW*i +: PW] |
| preempt_en | input | NCH | Channel may be suspended |
| preempt_ab | input | NCH | Channel may suspend others |
| act_valid | input | 1 | A channel is executing |
| act_idx | input | CW | Index of the executing channel |
| grant_valid | output | 1 | A channel is granted this cycle |
| grant_idx | output | CW | Index of the granted channel |
| grant_vec | output | NCH | One-hot grant |
| suspend_req | output | 1 | Asks the engine to suspend the active channel |
| prio_err | output | 1 | Priorities are not unique |
| halted | output | 1 | Halt state |

## Verification
The bench aims at the strict comparison in preemption. An equal-priority requester must not take over, and a `>=` slip would show up as a spurious suspend. It walks the rotating pointer across the wrap from channel 9 back to 1 and then to 0, where an off-by-one start would re-grant the last winner. It runs the halt flow with clear and error in the same cycle, where a clear-wins design would drop `halted` too early. It also checks that the debug block takes effect in the same cycle and also blocks preemption, a case a design that gated only idle starts would miss.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int DEF_NCH = 16;
  localparam int DEF_PW  = 4;

  typedef enum logic {
    SEL_FIXED  = 1'b0,
    SEL_ROTATE = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
  parameter int NCH = 16,
  parameter int PW  = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0]    mask,
  input  logic [NCH*PW-1:0] prio,
  output logic              found,
  output logic [CW-1:0]     idx,
  output logic [PW-1:0]     best
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < NCH; i++) begin
      if (mask[i] && (!found || prio[i*PW +: PW] > best)) begin
        found = 1'b1;
        idx   = CW'(i);
        best  = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask,
  input  logic [CW-1:0]  last,
  output logic           found,
  output logic [CW-1:0]  idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 1; k <= NCH; k++) begin
      if (!found && mask[(int'(last) + k) % NCH]) begin
        found = 1'b1;
        idx   = CW'((int'(last) + k) % NCH);
      end
    end
  end
endmodule

// File: rtl/arb_prio_dup.sv
module arb_prio_dup #(
  parameter int NCH = 16,
  parameter int PW  = 4
) (
  input  logic [NCH*PW-1:0] prio,
  output logic              dup
);
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      for (int j = i + 1; j < NCH; j++) begin
        if (prio[i*PW +: PW] == prio[j*PW +: PW]) dup = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH = DEF_NCH,
  parameter int PW  = DEF_PW,
  localparam int CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rr_mode,
  input  logic              halt_on_err,
  input  logic              halt_clr,
  input  logic              dbg_mode,
  input  logic              err_in,
  input  logic [NCH-1:0]    req,
  input  logic [NCH*PW-1:0] prio,
  input  logic [NCH-1:0]    preempt_en,
  input  logic [NCH-1:0]    preempt_ab,
  input  logic              act_valid,
  input  logic [CW-1:0]     act_idx,
  output logic              grant_valid,
  output logic [CW-1:0]     grant_idx,
  output logic [NCH-1:0]    grant_vec,
  output logic              suspend_req,
  output logic              prio_err,
  output logic              halted
);
  // idle selection
  logic          fix_found, rr_found;
  logic [CW-1:0] fix_idx, rr_idx;
  logic [PW-1:0] fix_best;
  // preemption selection
  logic [NCH-1:0] act_oh, pre_mask;
  logic           pre_found;
  logic [CW-1:0]  pre_idx;
  logic [PW-1:0]  pre_best, act_prio;
  logic           pre_ok, idle_found, cand_valid, blocked;
  logic [CW-1:0]  idle_idx;
  // state
  logic          halt_q, halt_d, halt_set;
  logic [CW-1:0] last_q, last_d;
  logic          last_en;
  sel_mode_e     mode;

  assign mode = sel_mode_e'(rr_mode);

  arb_fixed_pick #(.NCH(NCH), .PW(PW)) u_fix (
    .mask(req), .prio(prio), .found(fix_found), .idx(fix_idx), .best(fix_best)
  );

  arb_rr_pick #(.NCH(NCH)) u_rr (
    .mask(req), .last(last_q), .found(rr_found), .idx(rr_idx)
  );

  always_comb begin
    act_oh          = '0;
    act_oh[act_idx] = 1'b1;
  end

  assign pre_mask = req & preempt_ab & ~act_oh;
  assign act_prio = prio[act_idx*PW +: PW];

  arb_fixed_pick #(.NCH(NCH), .PW(PW)) u_pre (
    .mask(pre_mask), .prio(prio), .found(pre_found), .idx(pre_idx), .best(pre_best)
  );

  arb_prio_dup #(.NCH(NCH), .PW(PW)) u_dup (
    .prio(prio), .dup(prio_err)
  );

  // candidate and gating
  always_comb begin
    idle_found = (mode == SEL_ROTATE) ? rr_found : fix_found;
    idle_idx   = (mode == SEL_ROTATE) ? rr_idx   : fix_idx;
    pre_ok     = act_valid && preempt_en[act_idx] && pre_found && (pre_best > act_prio);
    cand_valid = act_valid ? pre_ok : idle_found;
    blocked    = halt_q | dbg_mode;
    grant_valid = cand_valid & ~blocked;
    grant_idx   = act_valid ? pre_idx : idle_idx;
    suspend_req = act_valid & grant_valid;
    grant_vec   = '0;
    if (grant_valid) grant_vec[grant_idx] = 1'b1;
  end

  // next state
  always_comb begin
    halt_set = halt_on_err & (err_in | prio_err);
    if (halt_set)      halt_d = 1'b1;
    else if (halt_clr) halt_d = 1'b0;
    else               halt_d = halt_q;
    last_en = grant_valid && (mode == SEL_ROTATE);
    last_d  = grant_idx;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      last_q <= CW'(NCH - 1);
    end else begin
      halt_q <= halt_d;
      if (last_en) last_q <= last_d;
    end
  end

  assign halted = halt_q;
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int NCH = 16,
  parameter int PW  = 4,
  localparam int CW = $clog2(NCH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halt_on_err,
  input logic              halt_clr,
  input logic              dbg_mode,
  input logic              err_in,
  input logic [NCH-1:0]    req,
  input logic [NCH*PW-1:0] prio,
  input logic [NCH-1:0]    preempt_en,
  input logic [NCH-1:0]    preempt_ab,
  input logic              act_valid,
  input logic [CW-1:0]     act_idx,
  input logic              grant_valid,
  input logic [CW-1:0]     grant_idx,
  input logic [NCH-1:0]    grant_vec,
  input logic              suspend_req,
  input logic              halted
);
  logic [PW-1:0] gp, ap;
  assign gp = prio[grant_idx*PW +: PW];
  assign ap = prio[act_idx*PW +: PW];

  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> req[grant_idx]); // R4
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec) && (grant_valid == (grant_vec != '0))); // R2
  AST_SUSPEND_RULES: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> act_valid && preempt_en[act_idx] && preempt_ab[grant_idx] && (gp > ap)); // R5
  AST_HALT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !grant_valid && !suspend_req); // R10
  AST_HALT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    halt_on_err && err_in |=> halted); // R10
  AST_HALT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    halted && halt_clr && !halt_on_err |=> !halted); // R12
  AST_DBG_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode |-> !grant_valid && !suspend_req); // R11
endmodule

bind dma_prio_arbiter dma_arb_checker #(.NCH(NCH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt_on_err(halt_on_err), .halt_clr(halt_clr),
  .dbg_mode(dbg_mode), .err_in(err_in), .req(req), .prio(prio),
  .preempt_en(preempt_en), .preempt_ab(preempt_ab), .act_valid(act_valid),
  .act_idx(act_idx), .grant_valid(grant_valid), .grant_idx(grant_idx),
  .grant_vec(grant_vec), .suspend_req(suspend_req), .halted(halted)
);

// File: tb/tb_dma_prio_arbiter.sv
module tb_dma_prio_arbiter;
  localparam int NCH = 16;
  localparam int PW  = 4;
  localparam int CW  = $clog2(NCH);

  logic clk, rst_n;
  logic rr_mode, halt_on_err, halt_clr, dbg_mode, err_in, act_valid;
  logic [NCH-1:0] req, preempt_en, preempt_ab;
  logic [NCH*PW-1:0] prio;
  logic [CW-1:0] act_idx;
  logic grant_valid, suspend_req, prio_err, halted;
  logic [CW-1:0] grant_idx;
  logic [NCH-1:0] grant_vec;

  dma_prio_arbiter #(.NCH(NCH), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .halt_on_err(halt_on_err),
    .halt_clr(halt_clr), .dbg_mode(dbg_mode), .err_in(err_in), .req(req),
    .prio(prio), .preempt_en(preempt_en), .preempt_ab(preempt_ab),
    .act_valid(act_valid), .act_idx(act_idx), .grant_valid(grant_valid),
    .grant_idx(grant_idx), .grant_vec(grant_vec), .suspend_req(suspend_req),
    .prio_err(prio_err), .halted(halted)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic  gv;
    int    gi;
    logic  sus;
    logic  perr;
    logic  hlt;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic step(input logic gv, input int gi, input logic sus,
                      input logic perr, input logic hlt, input string tag);
    exp_t e;
    #1;
    e.gv = gv; e.gi = gi; e.sus = sus; e.perr = perr; e.hlt = hlt; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      exp_t e;
      wait (q.size() != 0);
      e = q.pop_front();
      n_chk++;
      if (grant_valid !== e.gv || (e.gv && int'(grant_idx) != e.gi) ||
          (e.gv && grant_vec !== (NCH'(1) << e.gi)) || (!e.gv && grant_vec !== '0) ||
          suspend_req !== e.sus || prio_err !== e.perr || halted !== e.hlt) begin
        n_bad++;
        $display("FAIL %s: got gv=%b gi=%0d sus=%b perr=%b hlt=%b, exp gv=%b gi=%0d sus=%b perr=%b hlt=%b",
                 e.tag, grant_valid, grant_idx, suspend_req, prio_err, halted,
                 e.gv, e.gi, e.sus, e.perr, e.hlt);
      end
    end
  end

  task automatic setp(input int ch, input int v);
    prio[ch*PW +: PW] = PW'(v);
  endtask

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rr_mode = 0; halt_on_err = 0; halt_clr = 0; dbg_mode = 0;
    err_in = 0; act_valid = 0; act_idx = '0; req = '0;
    preempt_en = '1; preempt_ab = '1;
    for (int i = 0; i < NCH; i++) setp(i, i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(0, 0, 0, 0, 0, "R1 reset state");
    req = 16'h0084 | 16'h0008; step(1, 7, 0, 0, 0, "R2 highest priority");
    setp(2, 15); setp(15, 2); req = 16'h8084; step(1, 2, 0, 0, 0, "R2 reordered priority");
    req = '0; step(0, 0, 0, 0, 0, "R4 no request");
    // rotating
    rr_mode = 1;
    req = 16'h0021; step(1, 0, 0, 0, 0, "R1 rotation starts at 0");
    req = 16'h0222; step(1, 1, 0, 0, 0, "R3 rotate 1");
    step(1, 5, 0, 0, 0, "R3 rotate 5");
    step(1, 9, 0, 0, 0, "R3 rotate 9");
    step(1, 1, 0, 0, 0, "R3 wrap to 1");
    req = 16'h0003; step(1, 0, 0, 0, 0, "R3 wrap to 0");
    rr_mode = 0; setp(2, 2); setp(15, 15);
    // preemption, active channel 5
    act_valid = 1; act_idx = 5;
    req = 16'h0008; step(0, 0, 0, 0, 0, "R6 lower priority blocked");
    req = 16'h0100; step(1, 8, 1, 0, 0, "R5 preempt by higher");
    preempt_en[5] = 0; step(0, 0, 0, 0, 0, "R7 active not suspendable");
    preempt_en = '1;
    preempt_ab[8] = 0; req = 16'h0140; step(1, 6, 1, 0, 0, "R8 incapable requester skipped");
    preempt_ab = '1;
    setp(8, 5); req = 16'h0100; step(0, 0, 0, 1, 0, "R6 equal priority blocked / R9 conflict");
    setp(8, 8); step(1, 8, 1, 0, 0, "R9 conflict cleared");
    act_valid = 0;
    // halt
    req = 16'h0008;
    halt_on_err = 1; err_in = 1; step(1, 3, 0, 0, 0, "R10 error cycle");
    err_in = 0; step(0, 0, 0, 0, 1, "R10 halted blocks grant");
    halt_clr = 1; step(0, 0, 0, 0, 1, "R12 clear pending");
    halt_clr = 0; step(1, 3, 0, 0, 0, "R12 cleared");
    err_in = 1; step(1, 3, 0, 0, 0, "R12 error again");
    halt_clr = 1; step(0, 0, 0, 0, 1, "R12 error with clear");
    err_in = 0; halt_clr = 0; step(0, 0, 0, 0, 1, "R12 set won over clear");
    halt_clr = 1; step(0, 0, 0, 0, 1, "R12 clear issued");
    halt_clr = 0; step(1, 3, 0, 0, 0, "R12 released");
    halt_on_err = 0; err_in = 1; step(1, 3, 0, 0, 0, "R10 unarmed error");
    err_in = 0; step(1, 3, 0, 0, 0, "R10 unarmed no halt");
    halt_on_err = 1; setp(4, 5); step(1, 3, 0, 1, 0, "R9 conflict arms halt");
    setp(4, 4); halt_on_err = 0; step(0, 0, 0, 0, 1, "R10 conflict halted");
    halt_clr = 1; step(0, 0, 0, 0, 1, "R12 clear pending 2");
    halt_clr = 0; step(1, 3, 0, 0, 0, "R12 released 2");
    // debug
    dbg_mode = 1; step(0, 0, 0, 0, 0, "R11 debug blocks start");
    act_valid = 1; act_idx = 1; req = 16'h0400; step(0, 0, 0, 0, 0, "R11 debug blocks preempt");
    dbg_mode = 0; step(1, 10, 1, 0, 0, "R11 debug released");
    act_valid = 0; req = '0; step(0, 0, 0, 0, 0, "R4 idle end");
    wait (q.size() == 0);
    #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule